// File: doc/BRIEF.md
# Dual Sub-Timer Peripheral with Match Stop and Interrupt Window

The block holds two 16-bit sub-timers that share one slow tick-enable strobe, which is 32768 Hz on a typical system. Each sub-timer has three registers: a count register that software can load directly, a prescale divider, and a control register. The control register chooses whether the sub-timer runs, which way it counts, and when it stops. It can stop on reaching zero, stop on reaching one of six shared match registers, or run forever and wrap.

Only sub-timer 0 can raise an interrupt. When it steps onto its stop value, it sets bit 0 of a six-bit status register. That status register sits in a separate interrupt window together with a mask register, and their masked OR drives the single interrupt line. A typical setup uses sub-timer 0 for one-shot events: load a delay, then decrement toward a match register that holds 0. Sub-timer 1 typically runs as a free-running incrementing count that software reads.

Register access uses a simple synchronous bus. Writes take effect at the clock edge. Reads are combinational from the word address and the window select.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every count, divider and match register reads 0. Both control registers read 0x10 (stopped, decrement, stop-at-zero). Status and mask read 0, and `irq` is low.
- R2: Timer window word addresses map as follows. Sub-timer 0 uses 0 (count), 1 (divider) and 2 (control). Sub-timer 1 uses 3, 4 and 5 in the same order. Match registers 1 to 6 sit at addresses 6 to 11. In the interrupt window, address 0 is status/acknowledge and address 1 is the mask, which keeps only its low 6 bits.
- R3: While control bit 4 is 1, the count never changes except through a bus write.
- R4: With control bit 4 clear, the count steps once per qualifying `tick_en` pulse: upward when control bit 3 is 1, downward when it is 0. Without `tick_en` it does not move.
- R5: With a divider value N, the count steps on every (N+1)th tick. A write to the count register loads it and restarts the prescale phase.
- R6: Control bits 2:0 select the stop value. 0 selects zero, k in 1..6 selects match register k, and 7 selects none. Once the count equals its stop value, it holds there.
- R7: With bits 2:0 = 7, the count wraps from 0xFFFF to 0x0000 when counting up and from 0x0000 to 0xFFFF when counting down.
- R8: When sub-timer 0 steps onto its stop value, status bit 0 sets. Sub-timer 1 never changes status.
- R9: Writing ones to status clears those bits. If an event arrives in the same cycle as a clear, the event wins.
- R10: Status bits 5:1 have no source and always read 0.
- R11: `irq` is high exactly when some status bit and its mask bit are both 1.
- R12: A one-shot works as follows. Match register 1 = 0, count = D with D in 0x0001..0xFFFE, and control = 0x01 with divider 0. Status bit 0 then sets after exactly D ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow tick strobe, one cycle per tick |
| irq_win | input | 1 | 1 selects the interrupt window, 0 the timer window |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Word address within the selected window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr/irq_win |
| irq | output | 1 | Masked interrupt |

## Verification
The bench targets the step onto the stop value and the behaviour after it. A design that detected the stop one step late, or that kept counting past the target, would show a wrong count and a missing status bit 0 after an exact tick count. The prescaler is checked at the tick before and the tick of its first step, which catches an off-by-one divider. Wrap in both directions is checked in free-run mode. A design that let the acknowledge write beat a coincident event would lose that interrupt, and the bench hits that case directly. The bench also confirms that sub-timer 1 reaching zero leaves status untouched.

// File: rtl/dual_match_timer.sv
module dual_match_timer #(
  parameter int CW     = 16,
  parameter int NMATCH = 6,
  parameter int NSTAT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          irq_win,
  input  logic          wr,
  input  logic [3:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam int MBASE = 6;

  logic [CW-1:0]    match_q [NMATCH];
  logic [NSTAT-1:0] stat_q, mask_q, clr;

  wire twr = wr && !irq_win;
  wire iwr = wr && irq_win;

  for (genvar t = 0; t < 2; t++) begin : g_sub
    localparam int B = 3 * t;
    logic [CW-1:0] cnt, div, pre, target, nxt;
    logic [4:0]    ctl;
    logic          held, adv, step, ev;

    assign target = (ctl[2:0] == 3'd0 || ctl[2:0] == 3'd7) ? '0
                    : match_q[3'(ctl[2:0] - 3'd1)];
    assign held = (ctl[2:0] != 3'd7) && (cnt == target);
    assign adv  = tick_en && !ctl[4] && !held;
    assign step = adv && (pre >= div);
    assign nxt  = ctl[3] ? cnt + 1'b1 : cnt - 1'b1;
    assign ev   = step && (ctl[2:0] != 3'd7) && (nxt == target);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        div <= '0;
        pre <= '0;
        ctl <= 5'h10;
      end else begin
        if (twr && addr == 4'(B)) begin
          cnt <= wdata;
          pre <= '0;
        end else if (adv) begin
          if (step) begin
            pre <= '0;
            cnt <= nxt;
          end else begin
            pre <= pre + 1'b1;
          end
        end
        if (twr && addr == 4'(B + 1)) div <= wdata;
        if (twr && addr == 4'(B + 2)) ctl <= wdata[4:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < NMATCH; m++) match_q[m] <= '0;
    end else begin
      for (int m = 0; m < NMATCH; m++)
        if (twr && addr == 4'(MBASE + m)) match_q[m] <= wdata;
    end
  end

  assign clr = (iwr && addr == 4'd0) ? wdata[NSTAT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | {{(NSTAT-1){1'b0}}, g_sub[0].ev};
      if (iwr && addr == 4'd1) mask_q <= wdata[NSTAT-1:0];
    end
  end

  assign irq = |(stat_q & mask_q);

  always_comb begin
    rdata = '0;
    if (irq_win) begin
      if (addr == 4'd0)      rdata[NSTAT-1:0] = stat_q;
      else if (addr == 4'd1) rdata[NSTAT-1:0] = mask_q;
    end else begin
      case (addr)
        4'd0: rdata = g_sub[0].cnt;
        4'd1: rdata = g_sub[0].div;
        4'd2: rdata[4:0] = g_sub[0].ctl;
        4'd3: rdata = g_sub[1].cnt;
        4'd4: rdata = g_sub[1].div;
        4'd5: rdata[4:0] = g_sub[1].ctl;
        default:
          if (addr >= 4'(MBASE) && addr < 4'(MBASE + NMATCH))
            rdata = match_q[3'(addr - 4'(MBASE))];
      endcase
    end
  end
endmodule

// File: rtl/dual_match_timer_chk.sv
module dual_match_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic        irq_win,
  input logic [3:0]  addr,
  input logic [15:0] cnt0,
  input logic [4:0]  ctl0,
  input logic [5:0]  stat,
  input logic [5:0]  mask,
  input logic        irq
);
  wire cnt0_wr = wr && !irq_win && addr == 4'd0;

  assert_stop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0[4] && !cnt0_wr) |=> $stable(cnt0));

  assert_hold_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl0[4] && ctl0[2:0] == 3'd0 && cnt0 == 16'd0 && !cnt0_wr) |=> cnt0 == 16'd0);

  assert_event_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> !$stable(cnt0));

  assert_no_reserved_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat[5:1] == 5'd0);

  assert_mask_gates_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 6'd0) |-> !irq);
endmodule

bind dual_match_timer dual_match_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .irq_win(irq_win), .addr(addr),
  .cnt0(g_sub[0].cnt), .ctl0(g_sub[0].ctl), .stat(stat_q), .mask(mask_q),
  .irq(irq)
);

// File: tb/dual_match_timer_bench.sv
module dual_match_timer_bench;
  logic        clk = 0, rst_n = 0, tick_en = 0, irq_win = 0, wr = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dual_match_timer u_dual_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .irq_win(irq_win), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(logic w, logic [3:0] a, logic [15:0] d);
    @(negedge clk); irq_win = w; addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic w, logic [3:0] a, output logic [15:0] d);
    @(negedge clk); irq_win = w; addr = a; #1 d = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rreg(0, 0, d); check("R1 cnt0", d, 16'h0);
    rreg(0, 2, d); check("R1 ctl0", d, 16'h10);
    rreg(0, 5, d); check("R1 ctl1", d, 16'h10);
    rreg(0, 11, d); check("R1 match6", d, 16'h0);
    rreg(1, 0, d); check("R1 status", d, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_map();
    logic [15:0] d;
    wreg(0, 8, 16'h1234); rreg(0, 8, d); check("R2 match3", d, 16'h1234);
    wreg(0, 4, 16'h0005); rreg(0, 4, d); check("R2 div1", d, 16'h0005);
    wreg(0, 4, 16'h0000);
    wreg(1, 1, 16'h00FF); rreg(1, 1, d); check("R2 mask width", d, 16'h003F);
    wreg(1, 1, 16'h0000);
  endtask

  task automatic t_stopped();
    logic [15:0] d;
    wreg(0, 0, 16'd5); wreg(0, 2, 16'h17);
    ticks(4); rreg(0, 0, d); check("R3 stopped holds", d, 16'd5);
    wreg(0, 2, 16'h07);
    repeat (5) @(negedge clk);
    rreg(0, 0, d); check("R4 no tick no step", d, 16'd5);
    ticks(2); rreg(0, 0, d); check("R4 decrement", d, 16'd3);
    wreg(0, 2, 16'h0F); ticks(3); rreg(0, 0, d); check("R4 increment", d, 16'd6);
    wreg(0, 2, 16'h10);
  endtask

  task automatic t_prescale();
    logic [15:0] d;
    wreg(0, 1, 16'd2); wreg(0, 0, 16'd10); wreg(0, 2, 16'h07);
    ticks(2); rreg(0, 0, d); check("R5 before step", d, 16'd10);
    ticks(1); rreg(0, 0, d); check("R5 first step", d, 16'd9);
    ticks(3); rreg(0, 0, d); check("R5 second step", d, 16'd8);
    wreg(0, 2, 16'h10); wreg(0, 1, 16'd0);
  endtask

  task automatic t_oneshot();
    logic [15:0] d;
    wreg(0, 6, 16'd0); wreg(0, 0, 16'd3); wreg(0, 2, 16'h01);
    ticks(2); rreg(1, 0, d); check("R12 not yet", d, 16'h0);
    ticks(1); rreg(1, 0, d); check("R12 fired at D", d, 16'h1);
    check("R11 masked off", {15'd0, irq}, 16'h0);
    wreg(1, 1, 16'h1); check("R11 irq on", {15'd0, irq}, 16'h1);
    ticks(3); rreg(0, 0, d); check("R6 held at match", d, 16'd0);
    wreg(1, 0, 16'h3F); rreg(1, 0, d); check("R9 ack clears", d, 16'h0);
    check("R11 irq off", {15'd0, irq}, 16'h0);
    wreg(0, 2, 16'h10);
  endtask

  task automatic t_match_up();
    logic [15:0] d;
    wreg(0, 8, 16'h0010); wreg(0, 0, 16'h000D); wreg(0, 2, 16'h0B);
    ticks(5); rreg(0, 0, d); check("R6 up to match3", d, 16'h0010);
    rreg(1, 0, d); check("R8 status bit0", d, 16'h1);
    wreg(1, 0, 16'h1);
    wreg(0, 0, 16'd2); wreg(0, 2, 16'h00);
    ticks(4); rreg(0, 0, d); check("R6 to zero", d, 16'd0);
    rreg(1, 0, d); check("R8 zero event", d, 16'h1);
    wreg(1, 0, 16'h1); wreg(0, 2, 16'h10);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    wreg(0, 3, 16'hFFFE); wreg(0, 5, 16'h0F);
    ticks(3); rreg(0, 3, d); check("R7 up wrap", d, 16'h0001);
    wreg(0, 0, 16'h0001); wreg(0, 2, 16'h07);
    ticks(2); rreg(0, 0, d); check("R7 down wrap", d, 16'hFFFF);
    wreg(0, 2, 16'h10);
    wreg(0, 3, 16'd2); wreg(0, 5, 16'h00);
    ticks(3); rreg(0, 3, d); check("R6 sub1 at zero", d, 16'd0);
    rreg(1, 0, d); check("R8 sub1 no status", d, 16'h0);
  endtask

  task automatic t_race();
    logic [15:0] d;
    wreg(0, 0, 16'd1); wreg(0, 2, 16'h00);
    @(negedge clk); irq_win = 1; addr = 0; wdata = 16'h1; wr = 1; tick_en = 1;
    @(negedge clk); wr = 0; tick_en = 0;
    rreg(1, 0, d); check("R9 event beats clear", d, 16'h1);
    wreg(1, 0, 16'h3E); rreg(1, 0, d); check("R10 reserved ack", d, 16'h1);
    wreg(1, 0, 16'h1); rreg(1, 0, d); check("R9 cleared", d, 16'h0);
    check("R10 reserved zero", d & 16'h3E, 16'h0);
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_stopped();
    t_prescale();
    t_oneshot();
    t_match_up();
    t_wrap();
    t_race();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule